// File: doc/BRIEF.md
# System Call and Trap Interrupt Entry

This block works out the architectural register updates a 64-bit core needs when it takes a system-call or trap-instruction interrupt. Each cycle it may receive one decoded operation. The operation comes with its class, the instruction word, the current instruction address and the current machine state register (MSR). One clock later the block presents four results: the saved return address (SRR0), the saved status word (SRR1), the new MSR value and the interrupt vector address. Alongside these it gives a one-cycle take strobe, or an illegal-instruction strobe when a system call has a malformed encoding.

Registers use big-endian bit numbering, so bit 0 is the most significant bit of a 64-bit value. The input side has a valid strobe and no ready signal. The block accepts one operation on every cycle that valid is high and never applies back-pressure, so the upstream stage must not expect any stall. Hypervisor levels, vectored system calls and instruction redirect are outside this block.

Top module: `intr_entry`

## Requirements
- R1: The operation class input is encoded as 0 = none, 1 = system call, 2 = trap instruction and 3 = none. A system call with valid high and instruction word bit 1 set (counted from the LSB, value 2) raises take_o on the next cycle, with vector_o = 0xC00.
- R2: A system call whose instruction word bit 1 is 0 raises illegal_o on the next cycle and leaves take_o low. SRR0, SRR1, the new MSR and the vector all keep their previous values.
- R3: On an accepted system call, srr0_o equals the current address plus 4, wrapping modulo 2^64.
- R4: On an accepted system call, srr1_o equals MSR AND NOT 0x00000000783F0000. This clears big-endian bits 33:36 and 42:47, so the trap flag (bit 46, value 0x20000) is 0.
- R5: A trap instruction with valid high raises take_o on the next cycle, with vector_o = 0x700 and srr0_o equal to the trapping instruction's own address.
- R6: On a trap, srr1_o equals (MSR AND NOT 0x00000000783F0000) OR 0x20000, which sets big-endian bit 46.
- R7: For both causes, msr_o becomes MSR AND 0x80000000783F0001. For example, 0x90000000783F2903 becomes 0x80000000783F0001.
- R8: When valid is low, or the class is none, take_o and illegal_o are low on the next cycle and all saved outputs hold their values.
- R9: take_o is high for exactly one cycle per accepted operation. Back-to-back accepted operations each update every output.
- R10: A synchronous active-high reset clears take_o, illegal_o, srr0_o, srr1_o, msr_o and vector_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | Operation class (0 none, 1 system call, 2 trap, 3 none) |
| insn_i | input | 32 | Instruction word |
| cia_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state register |
| take_o | output | 1 | Interrupt taken (one-cycle strobe) |
| illegal_o | output | 1 | Malformed system call (one-cycle strobe) |
| vector_o | output | 64 | Interrupt vector address |
| srr0_o | output | 64 | Saved return address |
| srr1_o | output | 64 | Saved status word |
| msr_o | output | 64 | New machine state register |

## Verification
On every cycle, the assertions check several invariants. The take and illegal strobes never coincide, and a taken interrupt always points to one of the two vectors. The trap flag in SRR1 agrees with the chosen vector, and the new MSR holds no bit outside the kept mask. The saved registers also stay unchanged on idle and illegal cycles. Only the bench's reference model can show that each value is correct: the exact SRR1 and MSR bit arithmetic, the plus-4 return address and its wraparound, and correct back-to-back updates under mixed streams of operations.

// File: rtl/ie_pkg.sv
package ie_pkg;
  typedef enum logic [1:0] {
    OPC_NONE = 2'd0,
    OPC_SC   = 2'd1,
    OPC_TRAP = 2'd2,
    OPC_RSV  = 2'd3
  } ie_opc_e;

  // convert a big-endian bit index into a little-endian one
  function automatic int be2le(input int width, input int be_idx);
    return width - 1 - be_idx;
  endfunction
endpackage

// File: rtl/ie_cause_decode.sv
module ie_cause_decode
  import ie_pkg::*;
#(
  parameter int ILEN   = 32,
  parameter int SC_BIT = 1
) (
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [ILEN-1:0] insn_i,
  output logic            do_sc_o,
  output logic            do_trap_o,
  output logic            bad_o
);
  ie_opc_e opc;
  logic    sc_form;

  always_comb begin
    opc       = ie_opc_e'(op_i);
    sc_form   = insn_i[SC_BIT];
    do_sc_o   = 1'b0;
    do_trap_o = 1'b0;
    bad_o     = 1'b0;
    if (valid_i) begin
      unique case (opc)
        OPC_SC: begin
          if (sc_form) do_sc_o = 1'b1;
          else         bad_o   = 1'b1;
        end
        OPC_TRAP: do_trap_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ie_ret_addr.sv
module ie_ret_addr #(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] cia_i,
  input  logic            next_i,
  output logic [XLEN-1:0] ret_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb ret_o = next_i ? (cia_i + STEP) : cia_i;
endmodule

// File: rtl/ie_status_form.sv
module ie_status_form
  import ie_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] CLR_MASK = 64'h0000_0000_783F_0000,
  parameter logic [XLEN-1:0] KEEP     = 64'h8000_0000_783F_0001,
  parameter int              TRAP_BE  = 46
) (
  input  logic [XLEN-1:0] msr_i,
  input  logic            is_trap_i,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o
);
  localparam int TRAP_LE = be2le(XLEN, TRAP_BE);

  logic [XLEN-1:0] flag;

  always_comb begin
    flag          = '0;
    flag[TRAP_LE] = is_trap_i;
    srr1_o        = (msr_i & ~CLR_MASK) | flag;
    msr_o         = msr_i & KEEP;
  end
endmodule

// File: rtl/intr_entry.sv
module intr_entry
  import ie_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter int              ILEN       = 32,
  parameter int              SC_BIT     = 1,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] SC_VEC     = 64'h0000_0000_0000_0C00,
  parameter logic [XLEN-1:0] TRAP_VEC   = 64'h0000_0000_0000_0700,
  parameter logic [XLEN-1:0] CLR_MASK   = 64'h0000_0000_783F_0000,
  parameter logic [XLEN-1:0] KEEP       = 64'h8000_0000_783F_0001,
  parameter int              TRAP_BE    = 46
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [ILEN-1:0] insn_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [XLEN-1:0] msr_i,
  output logic            take_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] vector_o,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o
);
  localparam int TRAP_LE = be2le(XLEN, TRAP_BE);

  logic            do_sc, do_trap, bad, accept;
  logic [XLEN-1:0] ret_addr, srr1_nx, msr_nx;

  ie_cause_decode #(.ILEN(ILEN), .SC_BIT(SC_BIT)) u_dec (
    .valid_i(valid_i), .op_i(op_i), .insn_i(insn_i),
    .do_sc_o(do_sc), .do_trap_o(do_trap), .bad_o(bad)
  );

  ie_ret_addr #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ret (
    .cia_i(cia_i), .next_i(do_sc), .ret_o(ret_addr)
  );

  ie_status_form #(.XLEN(XLEN), .CLR_MASK(CLR_MASK), .KEEP(KEEP),
                   .TRAP_BE(TRAP_BE)) u_stat (
    .msr_i(msr_i), .is_trap_i(do_trap), .srr1_o(srr1_nx), .msr_o(msr_nx)
  );

  assign accept = do_sc | do_trap;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o    <= 1'b0;
      illegal_o <= 1'b0;
      vector_o  <= '0;
      srr0_o    <= '0;
      srr1_o    <= '0;
      msr_o     <= '0;
    end else begin
      take_o    <= accept;
      illegal_o <= bad;
      if (accept) begin
        vector_o <= do_sc ? SC_VEC : TRAP_VEC;
        srr0_o   <= ret_addr;
        srr1_o   <= srr1_nx;
        msr_o    <= msr_nx;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(take_o && illegal_o)); // R2
  AST_VEC_KNOWN: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (vector_o == SC_VEC || vector_o == TRAP_VEC)); // R1
  AST_SC_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    (take_o && vector_o == SC_VEC) |-> !srr1_o[TRAP_LE]); // R4
  AST_TRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (take_o && vector_o == TRAP_VEC) |-> srr1_o[TRAP_LE]); // R6
  AST_MSR_KEPT: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((msr_o & ~KEEP) == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!take_o && !illegal_o && $stable(srr0_o) && $stable(srr1_o))); // R8
  AST_ILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($stable(srr0_o) && $stable(msr_o) && $stable(vector_o))); // R2
endmodule

// File: tb/test_intr_entry.sv
module test_intr_entry;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [31:0] insn_i = '0;
  logic [63:0] cia_i = '0, msr_i = '0;
  logic        take_o, illegal_o;
  logic [63:0] vector_o, srr0_o, srr1_o, msr_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic        e_take = 0, e_ill = 0;
  logic [63:0] e_vec = 0, e_s0 = 0, e_s1 = 0, e_msr = 0;

  always #10 clk = ~clk;

  intr_entry i_intr_entry (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .insn_i(insn_i),
    .cia_i(cia_i), .msr_i(msr_i), .take_o(take_o), .illegal_o(illegal_o),
    .vector_o(vector_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o)
  );

  // behavioural reference model built from the requirements
  always @(posedge clk) begin
    if (rst) begin
      e_take <= 0; e_ill <= 0; e_vec <= 0; e_s0 <= 0; e_s1 <= 0; e_msr <= 0;
    end else begin
      e_take <= 0; e_ill <= 0;
      if (valid_i && op_i == 2'd1 && insn_i[1]) begin
        e_take <= 1; e_vec <= 64'hC00; e_s0 <= cia_i + 64'd4;
        e_s1 <= msr_i & ~64'h783F0000; e_msr <= msr_i & 64'h80000000783F0001;
      end else if (valid_i && op_i == 2'd1) begin
        e_ill <= 1;
      end else if (valid_i && op_i == 2'd2) begin
        e_take <= 1; e_vec <= 64'h700; e_s0 <= cia_i;
        e_s1 <= (msr_i & ~64'h783F0000) | 64'h20000;
        e_msr <= msr_i & 64'h80000000783F0001;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 R5 R8 R9 take", {63'd0, take_o}, {63'd0, e_take});
    chk("R2 R8 illegal", {63'd0, illegal_o}, {63'd0, e_ill});
    chk("R1 R5 vector", vector_o, e_vec);
    chk("R3 R5 srr0", srr0_o, e_s0);
    chk("R4 R6 srr1", srr1_o, e_s1);
    chk("R7 msr", msr_o, e_msr);
  endtask

  // drive one cycle at the falling edge, then compare at the next falling edge
  task automatic step(input bit v, input logic [1:0] op, input logic [31:0] ins,
                      input logic [63:0] cia, input logic [63:0] msr);
    valid_i = v; op_i = op; insn_i = ins; cia_i = cia; msr_i = msr;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R10: reset state
    chk("R10 take", {63'd0, take_o}, 64'd0);
    chk("R10 illegal", {63'd0, illegal_o}, 64'd0);
    chk("R10 srr0", srr0_o, 64'd0);
    chk("R10 srr1", srr1_o, 64'd0);
    chk("R10 msr", msr_o, 64'd0);
    chk("R10 vector", vector_o, 64'd0);
    rst = 1'b0;
    // R1 R4 R7: worked example
    step(1, 2'd1, 32'h44000002, 64'h1128, 64'h90000000783F2903);
    chk("R7 example msr", msr_o, 64'h80000000783F0001);
    chk("R4 example srr1", srr1_o, 64'h9000000000002903);
    chk("R3 example srr0", srr0_o, 64'h112C);
    // R9: strobe drops
    step(0, 2'd1, 32'h44000002, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFF);
    // R2: malformed system call leaves state alone
    step(1, 2'd1, 32'h44000001, 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 srr0 kept", srr0_o, 64'h112C);
    // R5 R6: trap with all-ones MSR
    step(1, 2'd2, 32'h7FE00008, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 trap srr1", srr1_o, 64'hFFFF_FFFF_87C2_FFFF);
    chk("R5 trap srr0", srr0_o, 64'h4000);
    // R3: wraparound
    step(1, 2'd1, 32'h2, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0);
    chk("R3 wrap", srr0_o, 64'h0);
    // R8: class none and reserved
    step(1, 2'd0, 32'h2, 64'h5000, 64'h1234);
    step(1, 2'd3, 32'h2, 64'h6000, 64'h1234);
    // R9: back-to-back
    step(1, 2'd2, 32'h0, 64'h7000, 64'h1);
    step(1, 2'd1, 32'h2, 64'h8000, 64'h2);
    // mixed stream
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), $urandom,
           {$urandom, $urandom}, {$urandom, $urandom});
    valid_i = 0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule